// File: doc/BRIEF.md
# Configurable Clocked Serial Shift Engine

This block moves one byte at a time over a synchronous serial link. Software writes a small mode register to choose the wiring style, the bit order and the source of the serial clock. Writing a byte into the shift register starts a transfer. Eight clock periods later the received byte sits in the same register and a sticky interrupt request flag is raised.

Two wiring styles are offered. In the 3-wire style, a push-pull output pin and an input-only pin are used. In the 2-wire style, and in the serial-bus mode, one shared line is used. That line is open-drain: it is pulled low for a 0 and released for a 1. The serial clock comes from one of five places:
- an external pin, in which case the clock pin is an input;
- a timer output supplied from outside the block;
- the master clock divided by 8, 16 or 64.

With any internal source the block drives the clock pin itself.

For slave devices in serial-bus mode, a wake-up qualifier is available. While it is active, the data line stays released. The interrupt is raised only when the received byte equals the slave address input.

Top module: `sio_engine`

## Requirements
- R1: After reset, irqFlag is 0, shiftOut is 0 and sckOut is 1. The mode register resets to 0, which selects the external clock, so sckOe is 0.
- R2: Mode word `modeIn` holds the following fields. The clock select is in bits [1:0]. The transfer mode is in bits [3:2]: 00 = 3-wire MSB-first, 01 = 3-wire LSB-first, 10 = serial-bus, 11 = 2-wire. Bit 4 is the slow-clock alternate and bit 5 is wake-up. Every transfer mode except 01 sends and receives the most significant bit first.
- R3: Transfer mode 01 sends and receives the least significant bit first.
- R4: The clock is chosen by clock select together with bit 4, as follows.
  - 00: external pin.
  - 01 with bit4=0: the timer output; each one-cycle pulse on `timerTick` is one half period.
  - 01 with bit4=1: master clock /64.
  - 10: master clock /16.
  - 11: master clock /8.
  - With a divided source, the first falling edge of sckOut appears DIV/2 clock cycles after the write edge.
- R5: sckOe is 0 with the external source and 1 with any internal source. sckOut idles high.
- R6: A transfer presents each outgoing bit on a falling serial-clock edge and samples each incoming bit on a rising edge. It ends on the 8th rising edge: for a divided source this is 16*(DIV/2) cycles after the write edge.
- R7: irqFlag becomes 1 one clock cycle after the cycle of the 8th rising edge, and not before.
- R8: irqFlag is sticky. A pulse on irqClr clears it, and so does a write to the shift register (shiftWe).
- R9: With wake-up set in serial-bus mode, irqFlag is set at the end of a transfer only if the received byte equals slaveAddr.
- R10: While wake-up is set in serial-bus mode, sdoOe stays 0, so the data line is released.
- R11: In the 2-wire and serial-bus modes, sdoOut is always 0 and sdoOe=1 only while the current bit is 0. In the 3-wire modes, sdoOe is 1 and sdoOut carries the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeWe | input | 1 | Loads modeIn into the mode register |
| modeIn | input | 6 | Mode word (fields in R2) |
| shiftWe | input | 1 | Loads shiftIn and starts a transfer |
| shiftIn | input | 8 | Byte to send |
| slaveAddr | input | 8 | Address compared in wake-up mode |
| irqClr | input | 1 | Clears the interrupt flag |
| timerTick | input | 1 | Timer output pulse, one per half period |
| sckIn | input | 1 | External serial clock |
| sdiIn | input | 1 | 3-wire serial data input |
| lineIn | input | 1 | Level sensed on the shared open-drain line |
| shiftOut | output | 8 | Shift register contents (received byte) |
| irqFlag | output | 1 | Sticky end-of-transfer interrupt request |
| sckOut | output | 1 | Serial clock driven by the block |
| sckOe | output | 1 | Enable for sckOut |
| sdoOut | output | 1 | Serial data output value |
| sdoOe | output | 1 | Enable for sdoOut |

## Verification
The bench targets the following corner cases and the failure each one would expose.
- **Divided-clock timing.** It counts cycles from the write edge to the first falling edge, to the 8th rising edge and to the interrupt. A wrong half-period count or an off-by-one bit counter would shift these by whole periods.
- **Bit order.** It compares every bit on the line against the expected order for both orders. An engine that ignores the LSB-first setting would mirror the byte.
- **Wake-up.** It sends both a matching and a mismatching address with wake-up set. A missing address gate would raise the flag on the mismatch, and a data line that is not released would show zeros on the bus.
- **Flag clearing.** It checks that both a clear pulse and a new transfer drop the flag. A flag that is not sticky would lose the request before software reads it.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [1:0] {
    SRC_EXT  = 2'b00,
    SRC_TMR  = 2'b01,
    SRC_DIVA = 2'b10,
    SRC_DIVB = 2'b11
  } clkSrcE;

  typedef enum logic [1:0] {
    XM_3W_MSB = 2'b00,
    XM_3W_LSB = 2'b01,
    XM_BUS    = 2'b10,
    XM_2W     = 2'b11
  } xferModeE;

  typedef struct packed {
    logic       wake;
    logic       slowAlt;
    logic [1:0] xferMode;
    logic [1:0] clkSel;
  } modeS;

  typedef struct packed {
    logic load;
    logic fall;
    logic rise;
    logic done;
  } strobeS;
endpackage

// File: rtl/sio_ctrl.sv
module sio_ctrl
  import sio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_A  = 16,
  parameter int DIV_B  = 8,
  parameter int DIV_C  = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] clkSel,
  input  logic       slowAlt,
  input  logic       shiftWe,
  input  logic       timerTick,
  input  logic       sckIn,
  output strobeS     strobe,
  output logic       busy,
  output logic       sckOut,
  output logic       sckOe
);
  localparam int MAXD  = (DIV_A > DIV_B) ? ((DIV_A > DIV_C) ? DIV_A : DIV_C)
                                         : ((DIV_B > DIV_C) ? DIV_B : DIV_C);
  localparam int CNT_W = $clog2(MAXD / 2) + 1;
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] HALF_A = CNT_W'(DIV_A / 2);
  localparam logic [CNT_W-1:0] HALF_B = CNT_W'(DIV_B / 2);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(DIV_C / 2);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] halfSel;
  logic [BIT_W-1:0] bitCnt;
  logic             sckInt;
  logic             useCnt;
  logic             isExt;
  logic             intEv;
  logic             sckS1, sckS2, sckS3;

  always_comb begin
    isExt   = (clkSel == SRC_EXT);
    useCnt  = 1'b0;
    halfSel = HALF_B;
    unique case (clkSel)
      SRC_DIVA: begin useCnt = 1'b1; halfSel = HALF_A; end
      SRC_DIVB: begin useCnt = 1'b1; halfSel = HALF_B; end
      SRC_TMR:  begin useCnt = slowAlt; halfSel = HALF_C; end
      default:  begin useCnt = 1'b0; halfSel = HALF_B; end
    endcase
    if (useCnt) intEv = busy && (cnt == halfSel - 1'b1);
    else        intEv = busy && (clkSel == SRC_TMR) && timerTick;

    strobe.load = shiftWe;
    if (isExt) begin
      strobe.fall = busy && sckS3 && !sckS2;
      strobe.rise = busy && !sckS3 && sckS2;
    end else begin
      strobe.fall = intEv && sckInt;
      strobe.rise = intEv && !sckInt;
    end
    strobe.done = strobe.rise && (bitCnt == LAST_BIT);
  end

  // two-flop synchronizer plus one stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckS1 <= 1'b1;
      sckS2 <= 1'b1;
      sckS3 <= 1'b1;
    end else begin
      sckS1 <= sckIn;
      sckS2 <= sckS1;
      sckS3 <= sckS2;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cnt    <= '0;
      bitCnt <= '0;
      sckInt <= 1'b1;
    end else if (shiftWe) begin
      busy   <= 1'b1;
      cnt    <= '0;
      bitCnt <= '0;
      sckInt <= 1'b1;
    end else if (busy) begin
      if (useCnt) cnt <= intEv ? '0 : cnt + 1'b1;
      if (!isExt && intEv) sckInt <= ~sckInt;
      if (strobe.rise) bitCnt <= bitCnt + 1'b1;
      if (strobe.done) busy <= 1'b0;
    end
  end

  assign sckOut = sckInt;
  assign sckOe  = !isExt;
endmodule

// File: rtl/sio_dp.sv
module sio_dp
  import sio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeS            strobe,
  input  logic [1:0]        xferMode,
  input  logic              wake,
  input  logic [DATA_W-1:0] shiftIn,
  input  logic [DATA_W-1:0] slaveAddr,
  input  logic              irqClr,
  input  logic              sdiIn,
  input  logic              lineIn,
  output logic [DATA_W-1:0] shiftOut,
  output logic              irqFlag,
  output logic              sdoOut,
  output logic              sdoOe
);
  logic [DATA_W-1:0] sr;
  logic              sdoBit;
  logic              doneQ;
  logic              lsbFirst;
  logic              shared;
  logic              wakeActive;
  logic              din;

  assign lsbFirst   = (xferMode == XM_3W_LSB);
  assign shared     = xferMode[1];
  assign wakeActive = wake && (xferMode == XM_BUS);
  assign din        = shared ? lineIn : sdiIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sr     <= '0;
      sdoBit <= 1'b1;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= strobe.done;
      if (strobe.load) begin
        sr <= shiftIn;
      end else begin
        if (strobe.fall) sdoBit <= lsbFirst ? sr[0] : sr[DATA_W-1];
        if (strobe.rise) begin
          if (lsbFirst) sr <= {din, sr[DATA_W-1:1]};
          else          sr <= {sr[DATA_W-2:0], din};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag <= 1'b0;
    end else if (strobe.load || irqClr) begin
      irqFlag <= 1'b0;
    end else if (doneQ && (!wakeActive || (sr == slaveAddr))) begin
      irqFlag <= 1'b1;
    end
  end

  always_comb begin
    if (shared) begin
      sdoOut = 1'b0;
      sdoOe  = !wakeActive && !sdoBit;
    end else begin
      sdoOut = sdoBit;
      sdoOe  = 1'b1;
    end
  end

  assign shiftOut = sr;
endmodule

// File: rtl/sio_engine.sv
module sio_engine
  import sio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_A  = 16,
  parameter int DIV_B  = 8,
  parameter int DIV_C  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWe,
  input  logic [5:0]        modeIn,
  input  logic              shiftWe,
  input  logic [DATA_W-1:0] shiftIn,
  input  logic [DATA_W-1:0] slaveAddr,
  input  logic              irqClr,
  input  logic              timerTick,
  input  logic              sckIn,
  input  logic              sdiIn,
  input  logic              lineIn,
  output logic [DATA_W-1:0] shiftOut,
  output logic              irqFlag,
  output logic              sckOut,
  output logic              sckOe,
  output logic              sdoOut,
  output logic              sdoOe
);
  modeS   modeQ;
  strobeS strobe;
  logic   busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       modeQ <= '0;
    else if (modeWe) modeQ <= modeS'(modeIn);
  end

  sio_ctrl #(
    .DATA_W(DATA_W), .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .clkSel(modeQ.clkSel), .slowAlt(modeQ.slowAlt),
    .shiftWe(shiftWe), .timerTick(timerTick), .sckIn(sckIn),
    .strobe(strobe), .busy(busy), .sckOut(sckOut), .sckOe(sckOe)
  );

  sio_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .xferMode(modeQ.xferMode), .wake(modeQ.wake),
    .shiftIn(shiftIn), .slaveAddr(slaveAddr), .irqClr(irqClr),
    .sdiIn(sdiIn), .lineIn(lineIn),
    .shiftOut(shiftOut), .irqFlag(irqFlag), .sdoOut(sdoOut), .sdoOe(sdoOe)
  );
endmodule

// File: rtl/sio_engine_chk.sv
module sio_engine_chk (
  input logic       clk,
  input logic       rstN,
  input logic       shiftWe,
  input logic       irqClr,
  input logic       irqFlag,
  input logic       sckOut,
  input logic       sdoOut,
  input logic       busy,
  input logic [5:0] modeBits
);
  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqClr || shiftWe) |=> !irqFlag);

  // R5
  ext_sck_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeBits[1:0] == 2'b00) |-> sckOut);

  // R6
  sck_moves_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sckOut) |-> $past(busy));

  // R7
  irq_after_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> !busy);

  // R11
  open_drain_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeBits[3] && $past(modeBits[3])) |-> !sdoOut);
endmodule

bind sio_engine sio_engine_chk u_chk (
  .clk(clk), .rstN(rstN), .shiftWe(shiftWe), .irqClr(irqClr),
  .irqFlag(irqFlag), .sckOut(sckOut), .sdoOut(sdoOut),
  .busy(busy), .modeBits(modeQ)
);

// File: tb/tb_sio_engine.sv
module tb_sio_engine;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeWe = 1'b0;
  logic [5:0] modeIn = '0;
  logic       shiftWe = 1'b0;
  logic [7:0] shiftIn = '0;
  logic [7:0] slaveAddr = 8'h5A;
  logic       irqClr = 1'b0;
  logic       timerTick = 1'b0;
  logic       sckIn = 1'b1;
  logic       sdiIn = 1'b0;
  logic       lineIn = 1'b1;
  logic [7:0] shiftOut;
  logic       irqFlag, sckOut, sckOe, sdoOut, sdoOe;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  tickEn  = 1'b0;
  bit  finished = 1'b0;

  sio_engine dut (
    .clk(clk), .rstN(rstN), .modeWe(modeWe), .modeIn(modeIn),
    .shiftWe(shiftWe), .shiftIn(shiftIn), .slaveAddr(slaveAddr),
    .irqClr(irqClr), .timerTick(timerTick), .sckIn(sckIn),
    .sdiIn(sdiIn), .lineIn(lineIn), .shiftOut(shiftOut),
    .irqFlag(irqFlag), .sckOut(sckOut), .sckOe(sckOe),
    .sdoOut(sdoOut), .sdoOe(sdoOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // timer output: one-cycle pulse every third cycle
  initial begin
    forever begin
      for (int ph = 0; ph < 3; ph++) begin
        @(negedge clk);
        timerTick <= tickEn && (ph == 2);
      end
    end
  end

  // source kinds: 0 ext, 1 timer, 2 /16, 3 /8, 4 /64
  function automatic logic [2:0] srcBits(input int kind);
    case (kind)
      0: return 3'b000;
      1: return 3'b001;
      2: return 3'b010;
      3: return 3'b011;
      default: return 3'b101;
    endcase
  endfunction

  function automatic int halfOf(input int kind);
    case (kind)
      2: return 8;
      3: return 4;
      4: return 32;
      default: return 0;
    endcase
  endfunction

  function automatic logic expBit(input logic [7:0] v, input int i, input bit lsb);
    return lsb ? v[i] : v[7-i];
  endfunction

  task automatic setMode(input int kind, input logic [1:0] xm, input bit wake);
    logic [2:0] s;
    s = srcBits(kind);
    @(negedge clk);
    modeIn <= {wake, s[2], xm, s[1:0]};
    modeWe <= 1'b1;
    @(negedge clk);
    modeWe <= 1'b0;
  endtask

  function automatic logic lineVal(input logic [1:0] xm);
    if (xm[1]) return sdoOe ? 1'b0 : 1'b1;
    return sdoOut;
  endfunction

  // transfer with a clock generated inside the block
  task automatic xferInt(input int kind, input logic [1:0] xm, input bit wake,
                         input logic [7:0] data, input logic [7:0] rx, input bit expIrq);
    bit lsb;
    int cyc, rises, half, endCyc;
    logic prevSck, cur;
    logic [7:0] tx;
    bit odOk, relOk;
    lsb = (xm == 2'b01);
    half = halfOf(kind);
    tickEn = (kind == 1);
    @(negedge clk);
    shiftIn <= data;
    shiftWe <= 1'b1;
    @(posedge clk);
    @(negedge clk);
    shiftWe <= 1'b0;
    // R8: a new transfer start clears the flag
    check(irqFlag == 1'b0, "R8 start clears irq", irqFlag, 0);
    check(sckOe == 1'b1, "R5 sckOe internal", sckOe, 1);
    cyc = 0; rises = 0; prevSck = 1'b1; tx = '0; odOk = 1; relOk = 1; endCyc = 0;
    while (rises < 8 && cyc < 4000) begin
      cur = sckOut;
      if (prevSck && !cur) begin
        if (rises == 0 && half != 0)
          // R4: first falling edge after one half period
          check(cyc == half, "R4 first fall", cyc, half);
        tx[rises] = lineVal(xm);
        if (xm[1] && sdoOut) odOk = 0;
        if (wake && sdoOe) relOk = 0;
        sdiIn  <= expBit(rx, rises, lsb);
        lineIn <= expBit(rx, rises, lsb);
      end
      if (!prevSck && cur) rises++;
      prevSck = cur;
      if (rises == 8) begin
        endCyc = cyc;
        // R7: not yet set in the cycle of the 8th rise
        check(irqFlag == 1'b0, "R7 irq not early", irqFlag, 0);
      end else begin
        @(posedge clk);
        cyc++;
        @(negedge clk);
      end
    end
    if (half != 0)
      // R6: eight rising edges take 16 half periods
      check(endCyc == 16 * half, "R6 transfer length", endCyc, 16 * half);
    @(posedge clk);
    @(negedge clk);
    // R7 / R9: flag one cycle after the 8th rise (gated in wake-up mode)
    check(irqFlag == expIrq, wake ? "R9 wake irq" : "R7 irq timing", irqFlag, expIrq);
    check(shiftOut == rx, lsb ? "R3 rx LSB-first" : "R2 rx MSB-first", shiftOut, rx);
    for (int i = 0; i < 8; i++) begin
      logic e;
      e = wake ? 1'b1 : expBit(data, i, lsb);
      if (tx[i] !== e) begin
        check(1'b0, lsb ? "R3 tx LSB-first" : "R2 tx MSB-first", tx, data);
        break;
      end
      if (i == 7) check(1'b1, "R2 tx", 0, 0);
    end
    if (xm[1]) check(odOk, "R11 open-drain never high", odOk, 1);
    else       check(sdoOe == 1'b1, "R11 push-pull enable", sdoOe, 1);
    if (wake)  check(relOk, "R10 line released", relOk, 1);
    tickEn = 0;
  endtask

  // transfer clocked from the external pin
  task automatic xferExt(input logic [1:0] xm, input logic [7:0] data, input logic [7:0] rx);
    bit lsb;
    logic [7:0] tx;
    lsb = (xm == 2'b01);
    @(negedge clk);
    shiftIn <= data;
    shiftWe <= 1'b1;
    @(negedge clk);
    shiftWe <= 1'b0;
    check(sckOe == 1'b0, "R5 sckOe external", sckOe, 0);
    for (int i = 0; i < 8; i++) begin
      sckIn <= 1'b0;
      repeat (5) @(negedge clk);
      tx[i] = lineVal(xm);
      sdiIn  <= expBit(rx, i, lsb);
      lineIn <= expBit(rx, i, lsb);
      if (i == 7) check(irqFlag == 1'b0, "R7 irq before 8th rise", irqFlag, 0);
      repeat (2) @(negedge clk);
      sckIn <= 1'b1;
      repeat (6) @(negedge clk);
    end
    check(irqFlag == 1'b1, "R7 irq after 8th rise (ext)", irqFlag, 1);
    check(shiftOut == rx, "R4 ext rx byte", shiftOut, rx);
    for (int i = 0; i < 8; i++)
      if (tx[i] !== expBit(data, i, lsb)) begin
        check(1'b0, "R4 ext tx byte", tx, data);
        break;
      end
  endtask

  initial begin
    void'($urandom(32'd24680));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(irqFlag == 1'b0, "R1 irq reset", irqFlag, 0);
    check(sckOut == 1'b1, "R1 sck idle", sckOut, 1);
    check(shiftOut == 8'h00, "R1 shift reset", shiftOut, 0);
    check(sckOe == 1'b0, "R1 sckOe reset", sckOe, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // directed: /8 timing, MSB-first 3-wire
    setMode(3, 2'b00, 0);
    xferInt(3, 2'b00, 0, 8'hA5, 8'h3C, 1);
    // R8: sticky then cleared by irqClr
    repeat (5) @(negedge clk);
    check(irqFlag == 1'b1, "R8 sticky", irqFlag, 1);
    irqClr <= 1'b1;
    @(negedge clk);
    irqClr <= 1'b0;
    check(irqFlag == 1'b0, "R8 clear pulse", irqFlag, 0);

    // directed: LSB-first on /16, 2-wire on /64, timer source
    setMode(2, 2'b01, 0);
    xferInt(2, 2'b01, 0, 8'h81, 8'h0F, 1);
    setMode(4, 2'b11, 0);
    xferInt(4, 2'b11, 0, 8'h6E, 8'hC1, 1);
    setMode(1, 2'b10, 0);
    xferInt(1, 2'b10, 0, 8'h12, 8'hF0, 1);

    // external clock, both orders
    setMode(0, 2'b00, 0);
    xferExt(2'b00, 8'hB4, 8'h2D);
    setMode(0, 2'b01, 0);
    xferExt(2'b01, 8'h4B, 8'hD2);

    // wake-up: mismatch then match (R9, R10)
    setMode(3, 2'b10, 1);
    xferInt(3, 2'b10, 1, 8'h00, 8'hA5, 0);
    xferInt(3, 2'b10, 1, 8'h00, slaveAddr, 1);
    // wake bit in 3-wire mode has no gating effect (R9)
    setMode(3, 2'b00, 1);
    xferInt(3, 2'b00, 0, 8'h77, 8'h11, 1);

    // constrained random mix
    for (int n = 0; n < 24; n++) begin
      int kind;
      logic [1:0] xm;
      logic [7:0] d, r;
      kind = 1 + int'($urandom_range(3));
      xm   = 2'($urandom_range(3));
      d    = 8'($urandom);
      r    = 8'($urandom);
      setMode(kind, xm, 0);
      xferInt(kind, xm, 0, d, r, 1);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule